// File: doc/BRIEF.md
# Register-Programmed I2C Master for Decoder Setup

This block configures an external video decoder over a two-wire I2C bus. Software writes a small set of byte registers: the 7-bit slave address, the decoder's internal register index (the subaddress) and a data byte. Writing the data byte sends a single-byte write to the decoder. Setting the read-trigger bit in the control register fetches one byte from the decoder into the data register.

A read is always preceded by a write of the subaddress. A control bit selects how the two parts are joined. With the bit set, they form one combined transfer with a repeated START. With the bit clear, they are two separate transfers joined by STOP and then a new START. A status register reports a busy flag, which software polls before collecting read data, and a no-acknowledge error flag. Both bus lines are open drain: the block only ever pulls a line low or releases it. Each bit lasts four phases of `QUARTER_CLKS` clocks.

Top module: `i2c_reg_master`

## Requirements
- R1: Writing register 2 (data) while idle stores the byte and sends START, {slave[6:0],0}, subaddress, data byte, STOP, each byte followed by a slave acknowledge slot.
- R2: Writing register 3 (control) with bit0=1 and bit1=1 sends START, {slave[6:0],0}, subaddress, repeated START, {slave[6:0],1}, then eight bits from the slave, a master ACK (SDA held low in the ninth clock), and STOP. The received byte lands in register 2.
- R3: Writing register 3 with bit0=1 and bit1=0 sends START, {slave[6:0],0}, subaddress, STOP, START, {slave[6:0],1}, the received byte with master ACK, and STOP. The byte lands in register 2.
- R4: Control bit1 (repeated start) has no effect on a write transaction. The bus sequence stays that of R1.
- R5: Status register 4 bit0 (busy) is high continuously from the clock after the launching write until the final STOP completes. It stays high for 116, 156 or 160 bit phases for a write, a combined read or a split read respectively.
- R6: After reset, registers 0 to 4 read 0x00 and both bus lines are released.
- R7: If SDA is high in any slave acknowledge slot, status bit1 (error) is set and the next bus event is STOP. A transaction that stops on a missing address acknowledge lasts 44 phases. The error bit clears when the next transaction is launched.
- R8: Register writes of any kind are ignored while busy. Such a write launches nothing and leaves every register value unchanged.
- R9: During byte bits, SCL is low for the first two phases and high for the last two, and SDA changes only while SCL is low. START and STOP are the only SDA changes made while SCL is high.
- R10: Register 3 reads back the repeated-start bit at bit1, and bit0 always reads 0. Register 0 (slave address) and register 1 (subaddress) read back their stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 slave, 1 subaddress, 2 data, 3 control, 4 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions take the following for granted:
- Register writes arrive as single-cycle strobes with a settled address.
- The bus slave moves SDA only while SCL is low.
- The bus slave never holds SCL.

The bench's slave model keeps to these by reacting only on the falling clock edge after it sees SCL fall. It also never drives SCL. The bench checks the exact order of START, STOP, bytes and acknowledge levels seen on the wires against sequences built from the requirements. Random subaddresses, data values and transaction kinds are mixed with directed cases for a missing acknowledge and for writes issued while busy.

// File: rtl/i2c_rm_pkg.sv
package i2c_rm_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned STEP_W = 4;

    localparam logic [2:0] RA_SLAVE = 3'd0;
    localparam logic [2:0] RA_SUB   = 3'd1;
    localparam logic [2:0] RA_DATA  = 3'd2;
    localparam logic [2:0] RA_CTRL  = 3'd3;
    localparam logic [2:0] RA_STAT  = 3'd4;

    typedef enum logic [2:0] {
        EL_START, EL_STOP, EL_ADDR_W, EL_SUBADDR, EL_WDATA, EL_ADDR_R, EL_RDATA, EL_END
    } elem_t;

    typedef struct packed {
        logic              busy;
        logic              rd;
        logic [STEP_W-1:0] step;
        logic [3:0]        bitn;
        logic [1:0]        phase;
        logic [BYTE_W-1:0] rxsh;
        logic              nack;
        logic              stop_now;
        logic              err;
    } seq_t;

    // Bus element at position idx of a transaction of the given kind.
    function automatic elem_t elem_at(input logic rd, input logic rs, input logic [STEP_W-1:0] idx);
        elem_t e;
        e = EL_END;
        case (idx)
            4'd0: e = EL_START;
            4'd1: e = EL_ADDR_W;
            4'd2: e = EL_SUBADDR;
            4'd3: e = !rd ? EL_WDATA : (rs ? EL_START : EL_STOP);
            4'd4: e = !rd ? EL_STOP  : (rs ? EL_ADDR_R : EL_START);
            4'd5: e = !rd ? EL_END   : (rs ? EL_RDATA : EL_ADDR_R);
            4'd6: e = !rd ? EL_END   : (rs ? EL_STOP : EL_RDATA);
            4'd7: e = (rd && !rs) ? EL_STOP : EL_END;
            default: e = EL_END;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/i2c_rm_timer.sv
module i2c_rm_timer #(
    parameter int unsigned QUARTER_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (QUARTER_CLKS > 1) ? $clog2(QUARTER_CLKS) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = 1'b0;
        if (!run) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == CW'(QUARTER_CLKS - 1)) begin
            tmr_d.cnt = '0;
            tick      = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= CW'(QUARTER_CLKS - 1));

endmodule

// File: rtl/i2c_rm_regs.sv
module i2c_rm_regs
    import i2c_rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              busy,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-1:0] slave,
    output logic [BYTE_W-1:0] subaddr,
    output logic [BYTE_W-1:0] data,
    output logic              rstart,
    output logic              go_write,
    output logic              go_read
);
    typedef struct packed {
        logic [BYTE_W-1:0] slave;
        logic [BYTE_W-1:0] sub;
        logic [BYTE_W-1:0] data;
        logic              rstart;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d   = regs_q;
        go_write = 1'b0;
        go_read  = 1'b0;
        if (wr && !busy) begin
            case (addr)
                RA_SLAVE: regs_d.slave = wdata;
                RA_SUB:   regs_d.sub   = wdata;
                RA_DATA: begin
                    regs_d.data = wdata;
                    go_write    = 1'b1;
                end
                RA_CTRL: begin
                    regs_d.rstart = wdata[1];
                    go_read       = wdata[0];
                end
                default: ;
            endcase
        end
        if (rx_load) regs_d.data = rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign slave   = regs_q.slave;
    assign subaddr = regs_q.sub;
    assign data    = regs_q.data;
    assign rstart  = regs_q.rstart;

    a_r8_slave_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr) |=> $stable(regs_q.slave));
    a_r8_sub_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr) |=> $stable(regs_q.sub));
    a_r4_rstart_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr) |=> $stable(regs_q.rstart));

endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
    import i2c_rm_pkg::*;
#(
    parameter int unsigned QUARTER_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe
);
    logic              tick;
    logic [BYTE_W-1:0] slave_r, sub_r, data_r, rx_byte, tx_byte;
    logic              rstart_r, go_write, go_read, rx_load, is_byte;
    elem_t             el;
    seq_t              seq_d, seq_q;

    i2c_rm_timer #(.QUARTER_CLKS(QUARTER_CLKS)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (seq_q.busy),
        .tick (tick)
    );

    i2c_rm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .busy    (seq_q.busy),
        .rx_load (rx_load),
        .rx_byte (rx_byte),
        .slave   (slave_r),
        .subaddr (sub_r),
        .data    (data_r),
        .rstart  (rstart_r),
        .go_write(go_write),
        .go_read (go_read)
    );

    // Current bus element and the byte it carries.
    always_comb begin
        el = seq_q.stop_now ? EL_STOP : elem_at(seq_q.rd, rstart_r, seq_q.step);
        is_byte = (el == EL_ADDR_W) || (el == EL_SUBADDR) || (el == EL_WDATA) ||
                  (el == EL_ADDR_R) || (el == EL_RDATA);
        case (el)
            EL_ADDR_W:  tx_byte = {slave_r[6:0], 1'b0};
            EL_ADDR_R:  tx_byte = {slave_r[6:0], 1'b1};
            EL_SUBADDR: tx_byte = sub_r;
            EL_WDATA:   tx_byte = data_r;
            default:    tx_byte = 8'hFF;
        endcase
    end

    // Open-drain line decode from element and phase.
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        if (seq_q.busy) begin
            case (el)
                EL_START: begin
                    scl_oe = (seq_q.phase == 2'd0) || (seq_q.phase == 2'd3);
                    sda_oe = seq_q.phase[1];
                end
                EL_STOP: begin
                    scl_oe = (seq_q.phase == 2'd0);
                    sda_oe = !seq_q.phase[1];
                end
                EL_RDATA: begin
                    scl_oe = !seq_q.phase[1];
                    sda_oe = (seq_q.bitn == 4'd8);
                end
                default: begin
                    scl_oe = !seq_q.phase[1];
                    sda_oe = (seq_q.bitn < 4'd8) && !tx_byte[3'd7 - seq_q.bitn[2:0]];
                end
            endcase
        end
    end

    // Sequencer next state.
    always_comb begin
        logic el_done;
        seq_d   = seq_q;
        rx_load = 1'b0;
        rx_byte = {seq_q.rxsh[6:0], sda_i};
        el_done = 1'b0;
        if (!seq_q.busy) begin
            if (go_write || go_read) begin
                seq_d      = '0;
                seq_d.busy = 1'b1;
                seq_d.rd   = go_read;
            end
        end else if (tick) begin
            if (is_byte && seq_q.phase == 2'd2) begin
                if (seq_q.bitn == 4'd8) begin
                    if (el != EL_RDATA && sda_i) begin
                        seq_d.nack = 1'b1;
                        seq_d.err  = 1'b1;
                    end
                end else if (el == EL_RDATA) begin
                    seq_d.rxsh = rx_byte;
                    rx_load    = (seq_q.bitn == 4'd7);
                end
            end
            seq_d.phase = seq_q.phase + 2'd1;
            if (seq_q.phase == 2'd3) begin
                el_done = !is_byte || (seq_q.bitn == 4'd8);
                if (!el_done) begin
                    seq_d.bitn = seq_q.bitn + 4'd1;
                end else begin
                    seq_d.bitn = '0;
                    if (seq_q.stop_now ||
                        elem_at(seq_q.rd, rstart_r, seq_q.step + 4'd1) == EL_END) begin
                        seq_d.busy     = 1'b0;
                        seq_d.stop_now = 1'b0;
                        seq_d.step     = '0;
                    end else begin
                        seq_d.step = seq_q.step + 4'd1;
                        if (seq_d.nack) seq_d.stop_now = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        case (reg_addr)
            RA_SLAVE: reg_rdata = slave_r;
            RA_SUB:   reg_rdata = sub_r;
            RA_DATA:  reg_rdata = data_r;
            RA_CTRL:  reg_rdata = {6'd0, rstart_r, 1'b0};
            RA_STAT:  reg_rdata = {6'd0, seq_q.err, seq_q.busy};
            default:  reg_rdata = 8'h00;
        endcase
    end

    a_r5_launch_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.busy && (go_write || go_read)) |=> seq_q.busy);
    a_r6_idle_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.busy |-> (!scl_oe && !sda_oe));
    a_r9_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_q.busy) && seq_q.busy && is_byte && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));
    a_r1_bit_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy |-> (seq_q.bitn <= 4'd8));

endmodule

// File: tb/i2c_reg_master_test.sv
module i2c_reg_master_test;
    localparam int unsigned QC = 4;
    localparam int EV_S = 1000;
    localparam int EV_P = 1001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe;
    logic       slv_pull;
    wire        scl = !scl_oe;
    wire        sda = !sda_oe && !slv_pull;

    always #10 clk = ~clk;

    i2c_reg_master #(.QUARTER_CLKS(QC)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_i(sda),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int checks = 0, fails = 0;
    int ev [0:63];
    int nev = 0;
    int expv [0:63];
    int nexp = 0;
    logic [7:0] mem [0:255];
    logic [6:0] dev_addr = 7'h21;

    // Behavioural slave, acting on the falling clock edge.
    logic ps, pd, active, txmode, matched, rw;
    int bitc, byte_no;
    logic [7:0] shin, txb, ptr;
    always @(negedge clk) begin
        if (!rst_n) begin
            ps = 1'b1; pd = 1'b1; active = 1'b0; txmode = 1'b0; matched = 1'b0; rw = 1'b0;
            bitc = 0; byte_no = 0; shin = 8'd0; txb = 8'd0; ptr = 8'd0; slv_pull = 1'b0;
        end else begin
            if (ps && scl && pd && !sda) begin
                if (nev < 64) ev[nev] = EV_S;
                nev++;
                bitc = 0; byte_no = 0; txmode = 1'b0; active = 1'b1; slv_pull = 1'b0;
            end else if (ps && scl && !pd && sda) begin
                if (nev < 64) ev[nev] = EV_P;
                nev++;
                active = 1'b0; txmode = 1'b0; slv_pull = 1'b0;
            end else if (!ps && scl && active) begin
                if (bitc < 8) shin = {shin[6:0], sda};
                else begin
                    if (nev < 64) ev[nev] = shin * 2 + int'(sda);
                    nev++;
                end
                bitc++;
            end else if (ps && !scl && active) begin
                if (bitc == 8) begin
                    if (txmode) slv_pull = 1'b0;
                    else begin
                        if (byte_no == 0) begin
                            matched = (shin[7:1] == dev_addr);
                            rw = shin[0];
                        end
                        slv_pull = matched;
                        if (matched && !rw && byte_no == 1) ptr = shin;
                        if (matched && !rw && byte_no == 2) mem[ptr] = shin;
                    end
                end else if (bitc == 9) begin
                    bitc = 0;
                    if (byte_no == 0 && matched && rw) begin
                        txmode = 1'b1; txb = mem[ptr]; slv_pull = !txb[7];
                    end else begin
                        txmode = 1'b0; slv_pull = 1'b0;
                    end
                    byte_no++;
                end else if (txmode && bitc >= 1 && bitc <= 7) begin
                    slv_pull = !txb[7 - bitc];
                end
            end
            ps = scl; pd = sda;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); reg_addr = a; #1; v = reg_rdata;
    endtask

    // Counts the falling edges at which status reports busy after the launch write.
    task automatic wait_idle(output int cyc);
        cyc = 0;
        reg_addr = 3'd4; #1;
        while (reg_rdata[0] && cyc < 5000) begin
            cyc++;
            @(negedge clk); #1;
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic int enc(input logic [7:0] b, input logic nak);
        return int'(b) * 2 + int'(nak);
    endfunction

    task automatic push(input int v);
        expv[nexp] = v; nexp++;
    endtask

    task automatic exp_write(input logic [7:0] sla, input logic [7:0] sub, input logic [7:0] d);
        nexp = 0;
        push(EV_S); push(enc({sla[6:0], 1'b0}, 1'b0)); push(enc(sub, 1'b0));
        push(enc(d, 1'b0)); push(EV_P);
    endtask

    task automatic exp_read(input logic [7:0] sla, input logic [7:0] sub, input logic [7:0] d, input bit rs);
        nexp = 0;
        push(EV_S); push(enc({sla[6:0], 1'b0}, 1'b0)); push(enc(sub, 1'b0));
        if (!rs) push(EV_P);
        push(EV_S); push(enc({sla[6:0], 1'b1}, 1'b0)); push(enc(d, 1'b0)); push(EV_P);
    endtask

    task automatic cmp_log(input string req);
        chk(req, nev, nexp);
        for (int i = 0; i < nexp && i < nev && i < 64; i++) chk(req, ev[i], expv[i]);
    endtask

    task automatic do_write(input logic [7:0] sla, input logic [7:0] sub, input logic [7:0] d,
                            input bit rs, output int cyc);
        wr_reg(3'd0, sla); wr_reg(3'd1, sub); wr_reg(3'd3, {6'd0, rs, 1'b0});
        nev = 0;
        wr_reg(3'd2, d);
        wait_idle(cyc);
    endtask

    task automatic do_read(input logic [7:0] sla, input logic [7:0] sub, input bit rs, output int cyc);
        wr_reg(3'd0, sla); wr_reg(3'd1, sub);
        nev = 0;
        wr_reg(3'd3, {6'd0, rs, 1'b1});
        wait_idle(cyc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int cyc;
        void'($urandom(32'd5071));
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        #1;
        chk("R6 scl_oe", int'(scl_oe), 0);
        chk("R6 sda_oe", int'(sda_oe), 0);
        rst_n = 1'b1;
        for (int a = 0; a < 5; a++) begin
            rd_reg(3'(a), v);
            chk("R6 reset reg", int'(v), 0);
        end

        // R1 write, R5 length
        do_write(8'h21, 8'h0A, 8'h5C, 1'b0, cyc);
        exp_write(8'h21, 8'h0A, 8'h5C); cmp_log("R1 write sequence");
        chk("R1 slave received", int'(mem[8'h0A]), 8'h5C);
        chk("R5 write busy length", cyc, 116 * QC);
        rd_reg(3'd0, v); chk("R10 slave readback", int'(v), 8'h21);
        rd_reg(3'd1, v); chk("R10 sub readback", int'(v), 8'h0A);

        // R4 write with repeated start selected
        do_write(8'h21, 8'h11, 8'hA3, 1'b1, cyc);
        exp_write(8'h21, 8'h11, 8'hA3); cmp_log("R4 write ignores rstart");
        chk("R4 busy length", cyc, 116 * QC);
        rd_reg(3'd3, v); chk("R10 ctrl readback", int'(v), 8'h02);

        // R2 combined read
        mem[8'h40] = 8'hB6;
        do_read(8'h21, 8'h40, 1'b1, cyc);
        exp_read(8'h21, 8'h40, 8'hB6, 1'b1); cmp_log("R2 combined read");
        chk("R5 combined busy length", cyc, 156 * QC);
        rd_reg(3'd2, v); chk("R2 data captured", int'(v), 8'hB6);

        // R3 split read
        mem[8'h81] = 8'h4D;
        do_read(8'h21, 8'h81, 1'b0, cyc);
        exp_read(8'h21, 8'h81, 8'h4D, 1'b0); cmp_log("R3 split read");
        chk("R5 split busy length", cyc, 160 * QC);
        rd_reg(3'd2, v); chk("R3 data captured", int'(v), 8'h4D);

        // R7 missing acknowledge
        do_write(8'h35, 8'h02, 8'h77, 1'b0, cyc);
        nexp = 0; push(EV_S); push(enc(8'h6A, 1'b1)); push(EV_P);
        cmp_log("R7 stop after nack");
        chk("R7 nack busy length", cyc, 44 * QC);
        rd_reg(3'd4, v); chk("R7 error flag", int'(v), 8'h02);
        do_write(8'h21, 8'h03, 8'h19, 1'b0, cyc);
        rd_reg(3'd4, v); chk("R7 error cleared", int'(v), 8'h00);

        // R8 writes while busy
        wr_reg(3'd0, 8'h21); wr_reg(3'd1, 8'h22); wr_reg(3'd3, 8'h00);
        nev = 0;
        wr_reg(3'd2, 8'h66);
        wr_reg(3'd1, 8'h99); wr_reg(3'd2, 8'h12); wr_reg(3'd3, 8'h03); wr_reg(3'd0, 8'h50);
        wait_idle(cyc);
        exp_write(8'h21, 8'h22, 8'h66); cmp_log("R8 single transaction");
        rd_reg(3'd0, v); chk("R8 slave kept", int'(v), 8'h21);
        rd_reg(3'd1, v); chk("R8 sub kept", int'(v), 8'h22);
        rd_reg(3'd2, v); chk("R8 data kept", int'(v), 8'h66);
        rd_reg(3'd3, v); chk("R8 ctrl kept", int'(v), 8'h00);
        chk("R8 mem", int'(mem[8'h22]), 8'h66);

        // Random mix (R1, R2, R3, R9 via exact lengths)
        for (int n = 0; n < 18; n++) begin
            int kind;
            logic [7:0] sub, d;
            kind = int'($urandom % 3);
            sub = 8'($urandom);
            d = 8'($urandom);
            if (kind == 0) begin
                do_write(8'h21, sub, d, 1'($urandom), cyc);
                exp_write(8'h21, sub, d); cmp_log("R1 random write");
                chk("R9 random write length", cyc, 116 * QC);
            end else begin
                mem[sub] = d;
                do_read(8'h21, sub, kind == 1, cyc);
                exp_read(8'h21, sub, d, kind == 1);
                cmp_log(kind == 1 ? "R2 random read" : "R3 random read");
                chk("R9 random read length", cyc, (kind == 1 ? 156 : 160) * QC);
                rd_reg(3'd2, v); chk("R2 R3 random data", int'(v), int'(d));
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule